// File: doc/BRIEF.md
# Canonic Signed-Digit Constant Multiplier

This block scales a stream of signed integers by a single integer constant fixed when the design is elaborated. It uses no general multiplier. During elaboration a constant function rewrites the constant as a string of signed digits, each -1, 0 or +1, with the smallest possible number of nonzero digits. Each nonzero digit becomes one copy of the input shifted left by the digit's position. A copy is negated for a -1 digit. The copies are then summed in a tree of adders with a register after every level. Zero digits cost nothing, and a constant that is a power of two reduces to a registered shift.

The recoding scans from the least significant bit. When the remaining value is odd, the rule picks whichever digit (+1 or -1) leaves a multiple of four. This rule is deterministic and never places two nonzero digits side by side. For 125 it produces 2^7 - 2^2 + 2^0, which is three terms. A negative constant uses the recoding of its magnitude with every digit sign flipped. The product is DW + bitlen(|COEF|) + 1 bits wide, so it cannot overflow.

Both stream edges use valid/ready. A word moves in on a cycle where `in_valid` and `in_ready` are both high. A word moves out on a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the whole pipeline freezes: `in_ready` drops, and `out_data` and `out_valid` hold. In all other cases `in_ready` is high, and a bubble (`in_valid` low) travels through the pipeline as an invalid slot.

Top module: `csd_const_mult`

## Requirements
- R1: A word accepted with value x leaves as the exact signed product x*COEF, sign-extended to the full output width, for every x including the most negative input.
- R2: The latency is L = 1 + ceil(log2(T)) register stages, where T is the number of nonzero recoded digits (T taken as 1 when it is 0). A word accepted at a rising edge is visible after the L-th rising edge, counting the accepting edge as the first, provided `out_ready` stays high.
- R3: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and on the next cycle `out_valid` is still high and `out_data` is unchanged. No input is taken during the stall.
- R4: `in_ready` is high whenever `out_valid` is low or `out_ready` is high.
- R5: In the cycle after `rst` (synchronous, active high) is sampled high, `out_valid` is low.
- R6: The recoding has no two adjacent nonzero digits and no term for a zero digit. For COEF = 125 this gives three terms and therefore a latency of 3.
- R7: A power-of-two constant 2^n gives a single shifted term with no adder and a latency of 1. For COEF = 64, each input x appears as x*64.
- R8: COEF = 0 gives an output of 0 for every valid word, with a latency of 1.
- R9: A negative constant gives the correctly signed product. For COEF = -125, the output is -(x*125) with a latency of 3.
- R10: A cycle with `in_valid` low produces no output word. `out_valid` stays low in the slot where that word would have appeared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | Product word present |
| out_ready | input | 1 | Consumer takes the product this cycle |
| out_data | output | DW+bitlen(\|COEF\|)+1 | Signed product |

## Verification
The bench uses the extreme inputs -128 and 127. An intermediate sum or an output that is one bit too narrow would wrap and flip sign on those inputs, and the same happens if a term is zero-extended instead of sign-extended. It checks latency cycle by cycle on four constants: 125, 64, 0 and -125. A wrong digit count, an extra adder level on a single term, or a missed sign flip for the negative constant each shows up as a wrong value or a product arriving a cycle early or late. A stall is held for several cycles while a new input is offered. A design that leaked data through the stall would change the held product or swallow that input. One that lost the word would never deliver 11*125 afterwards.

// File: rtl/csdm_pkg.sv
package csdm_pkg;

  function automatic int csd_bitlen(longint v);
    longint a;
    int n;
    a = (v < 0) ? -v : v;
    n = 0;
    for (int i = 0; i < 63; i++) begin
      if (a > 0) begin
        n++;
        a = a >> 1;
      end
    end
    return n;
  endfunction

  function automatic int csd_prod_w(int dw, longint c);
    return dw + csd_bitlen(c) + 1;
  endfunction

  // Signed-digit masks: neg_sel=0 returns the +1 positions, 1 the -1 positions
  function automatic logic [63:0] csd_digits(longint c, bit neg_sel);
    longint k;
    logic [63:0] pm;
    logic [63:0] nm;
    logic [63:0] tmp;
    pm = '0;
    nm = '0;
    k  = (c < 0) ? -c : c;
    for (int i = 0; i < 62; i++) begin
      if (k[0]) begin
        if (k[1]) begin
          nm[i] = 1'b1;
          k = k + 1;
        end else begin
          pm[i] = 1'b1;
          k = k - 1;
        end
      end
      k = k >> 1;
    end
    if (c < 0) begin
      tmp = pm;
      pm  = nm;
      nm  = tmp;
    end
    return neg_sel ? nm : pm;
  endfunction

  function automatic int csd_nz(longint c);
    logic [63:0] m;
    int n;
    m = csd_digits(c, 1'b0) | csd_digits(c, 1'b1);
    n = 0;
    for (int i = 0; i < 64; i++) if (m[i]) n++;
    return n;
  endfunction

  function automatic int csd_shift(longint c, int idx);
    logic [63:0] m;
    int n;
    int pos;
    m = csd_digits(c, 1'b0) | csd_digits(c, 1'b1);
    n = 0;
    pos = 0;
    for (int i = 0; i < 64; i++) begin
      if (m[i]) begin
        if (n == idx) pos = i;
        n++;
      end
    end
    return pos;
  endfunction

  function automatic bit csd_is_neg(longint c, int idx);
    logic [63:0] nm;
    nm = csd_digits(c, 1'b1);
    return nm[csd_shift(c, idx)];
  endfunction

  function automatic int csd_lvl_n(int nt, int l);
    return (nt + (1 << l) - 1) >> l;
  endfunction

  function automatic int csd_lvl_off(int nt, int l, int w);
    int s;
    s = 0;
    for (int i = 0; i < 64; i++) if (i < l) s += csd_lvl_n(nt, i) * w;
    return s;
  endfunction

endpackage

// File: rtl/csdm_terms.sv
module csdm_terms
  import csdm_pkg::*;
#(
  parameter int     DW   = 8,
  parameter int     PW   = 16,
  parameter longint COEF = 125,
  parameter int     NT   = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [DW-1:0]   din,
  output logic [NT*PW-1:0] terms_q
);
  localparam int NZ = csd_nz(COEF);

  logic signed [PW-1:0] ext;
  logic [NT*PW-1:0]     nxt;

  assign ext = {{(PW-DW){din[DW-1]}}, din};

  for (genvar k = 0; k < NT; k++) begin : g_term
    if (NZ == 0) begin : g_zero
      assign nxt[k*PW +: PW] = '0;
    end else begin : g_dig
      localparam int SH  = csd_shift(COEF, k);
      localparam bit NEG = csd_is_neg(COEF, k);
      if (NEG) begin : g_sub
        assign nxt[k*PW +: PW] = -(ext <<< SH);
      end else begin : g_add
        assign nxt[k*PW +: PW] = ext <<< SH;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     terms_q <= '0;
    else if (en) terms_q <= nxt;
  end

  AST_TERMS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(terms_q)); // R3
endmodule

// File: rtl/csdm_add_level.sv
module csdm_add_level #(
  parameter int W    = 16,
  parameter int N_IN = 3,
  localparam int N_OUT = (N_IN + 1) / 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [N_IN*W-1:0]  in_bus,
  output logic [N_OUT*W-1:0] out_bus
);
  logic [N_OUT*W-1:0] nxt;

  for (genvar j = 0; j < N_OUT; j++) begin : g_pair
    if (2*j + 1 < N_IN) begin : g_sum
      assign nxt[j*W +: W] = in_bus[2*j*W +: W] + in_bus[(2*j+1)*W +: W];
    end else begin : g_pass
      assign nxt[j*W +: W] = in_bus[2*j*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     out_bus <= '0;
    else if (en) out_bus <= nxt;
  end

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(out_bus)); // R3
endmodule

// File: rtl/csd_const_mult.sv
module csd_const_mult
  import csdm_pkg::*;
#(
  parameter int     DW   = 8,
  parameter longint COEF = 125
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [DW-1:0]                     in_data,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [csd_prod_w(DW, COEF)-1:0]   out_data
);
  localparam int PW     = csd_prod_w(DW, COEF);
  localparam int NZ     = csd_nz(COEF);
  localparam int NT     = (NZ == 0) ? 1 : NZ;
  localparam int LEVELS = $clog2(NT);
  localparam int LAT    = LEVELS + 1;
  localparam int TOTW   = csd_lvl_off(NT, LEVELS + 1, PW);

  logic            adv;
  logic            acc;
  logic [LAT-1:0]  vld_q;
  logic [TOTW-1:0] tree;

  assign out_valid = vld_q[LAT-1];
  assign adv       = !out_valid || out_ready;
  assign in_ready  = adv;
  assign acc       = in_valid && adv;

  csdm_terms #(.DW(DW), .PW(PW), .COEF(COEF), .NT(NT)) u_terms (
    .clk(clk), .rst(rst), .en(adv), .din(in_data),
    .terms_q(tree[NT*PW-1:0])
  );

  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    localparam int NI = csd_lvl_n(NT, l - 1);
    localparam int NO = csd_lvl_n(NT, l);
    localparam int OI = csd_lvl_off(NT, l - 1, PW);
    localparam int OO = csd_lvl_off(NT, l, PW);
    csdm_add_level #(.W(PW), .N_IN(NI)) u_add (
      .clk(clk), .rst(rst), .en(adv),
      .in_bus(tree[OI +: NI*PW]),
      .out_bus(tree[OO +: NO*PW])
    );
  end

  assign out_data = tree[csd_lvl_off(NT, LEVELS, PW) +: PW];

  if (LAT == 1) begin : g_vld1
    always_ff @(posedge clk) begin
      if (rst)      vld_q <= '0;
      else if (adv) vld_q <= acc;
    end
  end else begin : g_vldn
    always_ff @(posedge clk) begin
      if (rst)      vld_q <= '0;
      else if (adv) vld_q <= {vld_q[LAT-2:0], acc};
    end
  end

  // Shadow product pipeline used only by the assertions
  logic [PW-1:0] ref_q [LAT];
  always_ff @(posedge clk) begin
    if (adv) begin
      ref_q[0] <= PW'(longint'($signed(in_data)) * COEF);
      for (int i = 1; i < LAT; i++) ref_q[i] <= ref_q[i-1];
    end
  end

  AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_data == ref_q[LAT-1]); // R1
  AST_STALL_HOLDS_VALID: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid); // R3
  AST_STALL_HOLDS_DATA: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> $stable(out_data)); // R3
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready); // R3
  AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready); // R4
  AST_RESET_CLEARS: assert property (@(posedge clk)
    $past(rst) |-> !out_valid); // R5
  if (NZ == 0) begin : g_zero_chk
    AST_ZERO_COEF_OUT: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> out_data == '0); // R8
  end
endmodule

// File: tb/csd_const_mult_tb_top.sv
`timescale 1ns/1ps
module csd_const_mult_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic out_ready = 1'b1;
  logic [7:0] in_data = '0;

  logic rdy_i, rdy_p, rdy_z, rdy_n;
  logic v_i, v_p, v_z, v_n;
  logic [15:0] o_i, o_p, o_n;
  logic [8:0]  o_z;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  csd_const_mult #(.DW(8), .COEF(125)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_i), .in_data(in_data),
    .out_valid(v_i), .out_ready(out_ready), .out_data(o_i));
  csd_const_mult #(.DW(8), .COEF(64)) dut_pow (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_p), .in_data(in_data),
    .out_valid(v_p), .out_ready(out_ready), .out_data(o_p));
  csd_const_mult #(.DW(8), .COEF(0)) dut_zero (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_z), .in_data(in_data),
    .out_valid(v_z), .out_ready(out_ready), .out_data(o_z));
  csd_const_mult #(.DW(8), .COEF(-125)) dut_neg (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(rdy_n), .in_data(in_data),
    .out_valid(v_n), .out_ready(out_ready), .out_data(o_n));

  localparam int NV = 10;
  localparam logic signed [7:0] VEC [NV] = '{8'sd0, 8'sd1, -8'sd1, 8'sd127, -8'sd128,
                                             8'sd5, -8'sd37, 8'sd100, 8'sd64, -8'sd2};

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic lane(input string req, input int lat, input logic v, input longint d,
                      input longint coef, input int c);
    int idx;
    idx = c - (lat - 1);
    if (idx >= 0 && idx < NV) begin
      chk(v == 1'b1, {req, " valid"}, longint'(v), 1);
      chk(d == longint'(VEC[idx]) * coef, {req, " data"}, d, longint'(VEC[idx]) * coef);
    end else begin
      chk(v == 1'b0, {"R10 ", req, " no word"}, longint'(v), 0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R5: reset state
    chk(!v_i && !v_p && !v_z && !v_n, "R5 reset idle", longint'(v_i), 0);

    // Vector walk, one word per cycle, then bubbles
    for (int c = 0; c < NV + 3; c++) begin
      in_valid = (c < NV);
      in_data  = (c < NV) ? VEC[c] : 8'd0;
      @(posedge clk);
      @(negedge clk);
      lane("R1 R2 R6", 3, v_i, longint'($signed(o_i)), 125, c);
      lane("R7", 1, v_p, longint'($signed(o_p)), 64, c);
      lane("R8", 1, v_z, longint'($signed(o_z)), 0, c);
      lane("R9", 3, v_n, longint'($signed(o_n)), -125, c);
      chk(rdy_i == 1'b1, "R4 ready with out_ready high", longint'(rdy_i), 1);
    end
    in_valid = 1'b0;

    // Back-pressure on a -37 word
    out_ready = 1'b0;
    in_valid  = 1'b1;
    in_data   = -8'sd37;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(v_i == 1'b1, "R3 stalled word valid", longint'(v_i), 1);
    chk($signed(o_i) == -4625, "R3 stalled word data", longint'($signed(o_i)), -4625);
    chk(rdy_i == 1'b0, "R3 in_ready low in stall", longint'(rdy_i), 0);
    in_valid = 1'b1;
    in_data  = 8'sd11;
    for (int s = 0; s < 3; s++) begin
      @(posedge clk);
      @(negedge clk);
      chk(v_i == 1'b1 && $signed(o_i) == -4625, "R3 held across stall",
          longint'($signed(o_i)), -4625);
      chk(rdy_i == 1'b0, "R3 input refused", longint'(rdy_i), 0);
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk(v_i == 1'b0, "R10 slot after drain empty", longint'(v_i), 0);
    chk(rdy_i == 1'b1, "R4 ready after drain", longint'(rdy_i), 1);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(v_i == 1'b1 && $signed(o_i) == 1375, "R3 word offered in stall delivered",
        longint'($signed(o_i)), 1375);

    // Reset while words are in flight
    in_valid = 1'b1;
    in_data  = 8'sd9;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(!v_i && !v_n && !v_p && !v_z, "R5 reset flushes", longint'(v_i), 0);
    rst = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(v_i == 1'b0, "R10 nothing after reset", longint'(v_i), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nchk, nfail);
    $finish;
  end
endmodule